// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Array

This block is a fully associative table of translation entries for a memory-management unit. Each entry covers one pair of adjacent virtual pages, and it gives each page of the pair its own physical frame. The even page uses the low half of the entry and the odd page uses the high half. Each half carries its own frame number, cache attribute, dirty bit and valid bit. The entry also stores a per-entry page mask, a virtual page number in 2 KB units (address bit 11 upward), an address-space identifier and a global bit.

There are two search paths.

- **Probe path.** It is combinational. It returns the index of the matching entry in the same cycle, or an all-ones value with a miss flag.
- **Lookup path.** It is registered. One cycle after a request it reports a hit flag, the index and the whole matched entry.

Entries are written one at a time at an index chosen by the surrounding logic. A flush command clears the whole table. The block leaves segment decoding, fault generation and the choice of victim entry to the stages around it. An entry whose two valid bits are both clear still matches, so that a later stage can raise an invalid-page condition.

Top module: `pp_tlb`

## Requirements
- R1: An entry matches a search VPN when the search VPN and the stored VPN agree in every bit position where that entry's mask bit is 0. Bit positions whose mask bit is 1 are not compared.
- R2: A match also needs the entry's global bit set, or the stored ASID equal to the search ASID. With the global bit set, the ASID is not compared.
- R3: When more than one entry matches, the entry with the lowest index is reported.
- R4: The probe outputs respond combinationally. On a match, `prb_miss` is 0 and `prb_idx` is the index, zero-extended to IDX_W+1 bits. On no match, `prb_miss` is 1 and `prb_idx` is all ones (-1).
- R5: A write with `wr_idx` at or above ENTRIES is ignored. No entry changes, including the entry the index would alias to in its low bits.
- R6: Reset, and a flush, each set every field of every entry to zero. Flush takes priority over a write in the same cycle. A cleared entry matches VPN 0 with ASID 0.
- R7: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_req` high. The other `rsp_*` outputs change only after a request and otherwise hold their values.
- R8: Each half is read back as a word with the frame number from bit 6 upward, the cache attribute in bits 5:3, dirty in bit 2, valid in bit 1 and the entry's global bit in bit 0. `rsp_lo_word` is the even half and `rsp_hi_word` the odd half. Write words use the same layout, except that bit 0 is ignored and the global bit comes from `wr_glob`.
- R9: An entry whose two valid bits are both 0 still takes part in matching.
- R10: A lookup in the same cycle as a write sees the table as it was before the write. Lookups from the next cycle on see the new contents.
- R11: A lookup that misses reports `rsp_hit` 0, `rsp_idx` 0, and zero in every entry field and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| rsp_valid | output | 1 | Lookup response present this cycle |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_idx | output | IDX_W | Index of the matched entry |
| rsp_mask | output | VPN_W | Page mask of the matched entry |
| rsp_vpn | output | VPN_W | VPN of the matched entry |
| rsp_asid | output | ASID_W | ASID of the matched entry |
| rsp_glob | output | 1 | Global bit of the matched entry |
| rsp_lo_word | output | WORD_W | Even-half readback word |
| rsp_hi_word | output | WORD_W | Odd-half readback word |
| prb_vpn | input | VPN_W | Probe virtual page number |
| prb_asid | input | ASID_W | Probe address-space identifier |
| prb_idx | output | IDX_W+1 | Probe result, all ones on miss |
| prb_miss | output | 1 | Probe found nothing |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W+1 | Target entry index |
| wr_mask | input | VPN_W | Page mask to store |
| wr_vpn | input | VPN_W | VPN to store |
| wr_asid | input | ASID_W | ASID to store |
| wr_glob | input | 1 | Global bit to store |
| wr_lo_word | input | WORD_W | Even-half contents, readback layout |
| wr_hi_word | input | WORD_W | Odd-half contents, readback layout |
| flush | input | 1 | Clear the whole table |

## Verification
Results are due at different times:

- **Probe results** have no register in their path. They are read one time unit after the probe inputs change, while the clock is low.
- **Lookup results** pass through one register. They are read at the falling edge that follows the rising edge that captured the request.
- **Writes and flushes** take effect at the rising edge where they are sampled. Every search that depends on them starts at a later falling edge.

The same-cycle write test places a lookup and a write in one cycle. It expects the old contents in the response to that lookup, and the new contents in the response to the next one.

// File: rtl/pp_tlb_pkg.sv
package pp_tlb_pkg;
  localparam int VPN_W  = 21;
  localparam int ASID_W = 8;
  localparam int PFN_W  = 20;
  localparam int CA_W   = 3;
  localparam int WORD_W = PFN_W + CA_W + 3;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [VPN_W-1:0]  mask;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    half_t             lo;
    half_t             hi;
  } entry_t;

  function automatic logic [WORD_W-1:0] pack_word(half_t h, logic g);
    return {h.pfn, h.cattr, h.dirty, h.valid, g};
  endfunction

  function automatic half_t unpack_word(logic [WORD_W-1:0] w);
    half_t h;
    h.pfn   = w[WORD_W-1 -: PFN_W];
    h.cattr = w[CA_W+2:3];
    h.dirty = w[2];
    h.valid = w[1];
    return h;
  endfunction
endpackage

// File: rtl/pp_tlb_entry.sv
module pp_tlb_entry
  import pp_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              flush,
  input  entry_t            wdata,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              lk_match,
  output logic              pr_match,
  output entry_t            q
);
  entry_t d;
  logic   en;

  function automatic logic cmp(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a, entry_t e);
    return ((((v ^ e.vpn) & ~e.mask) == '0) && (e.glob || (a == e.asid)));
  endfunction

  always_comb begin
    en = flush | we;
    d  = q;
    if (flush)   d = '0;
    else if (we) d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assign lk_match = cmp(lk_vpn, lk_asid, q);
  assign pr_match = cmp(pr_vpn, pr_asid, q);
endmodule

// File: rtl/pp_tlb_prio.sv
module pp_tlb_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pp_tlb.sv
module pp_tlb
  import pp_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PIDX_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [VPN_W-1:0]  rsp_mask,
  output logic [VPN_W-1:0]  rsp_vpn,
  output logic [ASID_W-1:0] rsp_asid,
  output logic              rsp_glob,
  output logic [WORD_W-1:0] rsp_lo_word,
  output logic [WORD_W-1:0] rsp_hi_word,
  input  logic [VPN_W-1:0]  prb_vpn,
  input  logic [ASID_W-1:0] prb_asid,
  output logic [PIDX_W-1:0] prb_idx,
  output logic              prb_miss,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [WORD_W-1:0] wr_lo_word,
  input  logic [WORD_W-1:0] wr_hi_word,
  input  logic              flush
);
  entry_t             ent_q [ENTRIES];
  entry_t             wdata;
  logic [ENTRIES-1:0] lk_vec, pr_vec, we_vec;
  logic               wr_ok;
  logic               lk_found, pr_found;
  logic [IDX_W-1:0]   lk_pidx, pr_pidx;
  entry_t             lk_sel;

  // write decode
  always_comb begin
    wr_ok       = wr_en && (wr_idx < PIDX_W'(ENTRIES));
    wdata.mask  = wr_mask;
    wdata.vpn   = wr_vpn;
    wdata.asid  = wr_asid;
    wdata.glob  = wr_glob;
    wdata.lo    = unpack_word(wr_lo_word);
    wdata.hi    = unpack_word(wr_hi_word);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign we_vec[g] = wr_ok && (wr_idx == PIDX_W'(g));
    pp_tlb_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_vec[g]),
      .flush    (flush),
      .wdata    (wdata),
      .lk_vpn   (lk_vpn),
      .lk_asid  (lk_asid),
      .pr_vpn   (prb_vpn),
      .pr_asid  (prb_asid),
      .lk_match (lk_vec[g]),
      .pr_match (pr_vec[g]),
      .q        (ent_q[g])
    );
  end

  pp_tlb_prio #(.N(ENTRIES), .IW(IDX_W)) u_lk_prio (
    .req (lk_vec), .found (lk_found), .idx (lk_pidx)
  );
  pp_tlb_prio #(.N(ENTRIES), .IW(IDX_W)) u_pr_prio (
    .req (pr_vec), .found (pr_found), .idx (pr_pidx)
  );

  // probe result
  always_comb begin
    prb_miss = !pr_found;
    prb_idx  = pr_found ? {1'b0, pr_pidx} : '1;
  end

  // lookup next state
  always_comb begin
    lk_sel = lk_found ? ent_q[lk_pidx] : '0;
  end

  entry_t           rsp_ent;
  logic             rsp_hit_q;
  logic [IDX_W-1:0] rsp_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit_q <= 1'b0;
      rsp_idx_q <= '0;
      rsp_ent   <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit_q <= lk_found;
        rsp_idx_q <= lk_found ? lk_pidx : '0;
        rsp_ent   <= lk_sel;
      end
    end
  end

  assign rsp_hit     = rsp_hit_q;
  assign rsp_idx     = rsp_idx_q;
  assign rsp_mask    = rsp_ent.mask;
  assign rsp_vpn     = rsp_ent.vpn;
  assign rsp_asid    = rsp_ent.asid;
  assign rsp_glob    = rsp_ent.glob;
  assign rsp_lo_word = pack_word(rsp_ent.lo, rsp_ent.glob);
  assign rsp_hi_word = pack_word(rsp_ent.hi, rsp_ent.glob);
endmodule

// File: rtl/pp_tlb_chk.sv
module pp_tlb_chk
  import pp_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PIDX_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              flush,
  input logic [VPN_W-1:0]  prb_vpn,
  input logic [ASID_W-1:0] prb_asid,
  input logic [PIDX_W-1:0] prb_idx,
  input logic              prb_miss,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_idx,
  input logic [WORD_W-1:0] rsp_lo_word
);
  AST_PROBE_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    prb_miss |-> (prb_idx == '1)); // R4
  AST_PROBE_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !prb_miss |-> (prb_idx < PIDX_W'(ENTRIES))); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(lk_req)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> ($stable(rsp_idx) && $stable(rsp_hit) && $stable(rsp_lo_word))); // R7
  AST_FLUSH_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && prb_vpn == '0 && prb_asid == '0) |-> (!prb_miss && prb_idx == '0)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_lo_word == '0)); // R11
endmodule

bind pp_tlb pp_tlb_chk #(.ENTRIES(ENTRIES)) u_pp_tlb_chk (.*);

// File: tb/test_pp_tlb.sv
module test_pp_tlb;
  import pp_tlb_pkg::*;
  localparam int ENTRIES = 8;
  localparam int IDX_W   = 3;
  localparam int PIDX_W  = 4;
  localparam int NV      = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_req;
  logic [VPN_W-1:0]  lk_vpn;
  logic [ASID_W-1:0] lk_asid;
  logic              rsp_valid, rsp_hit, rsp_glob;
  logic [IDX_W-1:0]  rsp_idx;
  logic [VPN_W-1:0]  rsp_mask, rsp_vpn;
  logic [ASID_W-1:0] rsp_asid;
  logic [WORD_W-1:0] rsp_lo_word, rsp_hi_word;
  logic [VPN_W-1:0]  prb_vpn;
  logic [ASID_W-1:0] prb_asid;
  logic [PIDX_W-1:0] prb_idx;
  logic              prb_miss;
  logic              wr_en, wr_glob, flush;
  logic [PIDX_W-1:0] wr_idx;
  logic [VPN_W-1:0]  wr_mask, wr_vpn;
  logic [ASID_W-1:0] wr_asid;
  logic [WORD_W-1:0] wr_lo_word, wr_hi_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pp_tlb #(.ENTRIES(ENTRIES)) i_pp_tlb (.*);

  // search table: vpn, asid, expect miss, expected index
  localparam logic [VPN_W-1:0]  T_VPN  [NV] = '{21'h100, 21'h100, 21'h101, 21'h202, 21'h203,
                                                21'h204, 21'h300, 21'h300, 21'h000};
  localparam logic [ASID_W-1:0] T_ASID [NV] = '{8'd5, 8'd6, 8'd5, 8'd3, 8'd9, 8'd7, 8'd1, 8'd2, 8'd0};
  localparam logic              T_MISS [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [IDX_W-1:0]  T_IDX  [NV] = '{3'd0, 3'd0, 3'd0, 3'd2, 3'd2, 3'd0, 3'd5, 3'd0, 3'd1};
  // 0:R1 exact, 1:R2 asid, 2:R1 unmasked bit, 3:R1 masked + R2 global, 4:R3 overlap,
  // 5:R1 outside mask, 6:R9 invalid entry, 7:R2 asid, 8:R6 zero entry lowest free

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [PIDX_W-1:0] idx, input logic [VPN_W-1:0] m, input logic [VPN_W-1:0] v,
                    input logic [ASID_W-1:0] a, input logic g,
                    input logic [WORD_W-1:0] lo, input logic [WORD_W-1:0] hi);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_mask = m; wr_vpn = v; wr_asid = a; wr_glob = g;
    wr_lo_word = lo; wr_hi_word = hi;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    @(negedge clk);
    prb_vpn = v; prb_asid = a;
    #1;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_asid = a;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_vpn = '0; lk_asid = '0; prb_vpn = '0; prb_asid = '0;
    wr_en = 1'b0; wr_idx = '0; wr_mask = '0; wr_vpn = '0; wr_asid = '0; wr_glob = 1'b0;
    wr_lo_word = '0; wr_hi_word = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    probe(21'h0, 8'h0);
    chk("R6 reset probe miss", 64'(prb_miss), 64'h0);
    chk("R6 reset probe idx", 64'(prb_idx), 64'h0);
    chk("R7 reset rsp_valid", 64'(rsp_valid), 64'h0);

    // populate; entry 0 lo word written with bit 0 set (must be ignored, R8)
    wr(4'd0, 21'h0, 21'h100, 8'd5, 1'b0, 26'h445F, 26'h8892);
    wr(4'd2, 21'h3, 21'h200, 8'd7, 1'b1, 26'h0A0A, 26'h0B0A);
    wr(4'd3, 21'h0, 21'h203, 8'd9, 1'b0, 26'h0C0A, 26'h0D0A);
    wr(4'd5, 21'h0, 21'h300, 8'd1, 1'b0, 26'h0E00, 26'h0F00);

    for (int k = 0; k < NV; k++) begin
      probe(T_VPN[k], T_ASID[k]);
      chk("R4 R1 R2 R3 R9 probe miss", 64'(prb_miss), 64'(T_MISS[k]));
      chk("R4 R1 R2 R3 R9 probe idx", 64'(prb_idx), T_MISS[k] ? 64'hF : 64'(T_IDX[k]));
      look(T_VPN[k], T_ASID[k]);
      chk("R7 rsp_valid", 64'(rsp_valid), 64'h1);
      chk("R1 R2 R3 R9 lookup hit", 64'(rsp_hit), 64'(!T_MISS[k]));
      chk("R3 lookup idx", 64'(rsp_idx), 64'(T_IDX[k]));
      if (T_MISS[k]) begin
        chk("R11 miss words", {32'(rsp_lo_word), 32'(rsp_hi_word)}, 64'h0);
        chk("R11 miss fields", {rsp_mask, rsp_vpn, rsp_asid, rsp_glob}, 64'h0);
      end
    end

    // R8 readback layout
    look(21'h100, 8'd5);
    chk("R8 lo word", 64'(rsp_lo_word), 64'h445E);
    chk("R8 hi word", 64'(rsp_hi_word), 64'h8892);
    chk("R8 vpn asid", {rsp_vpn, rsp_asid}, {21'h100, 8'd5});
    look(21'h201, 8'd0);
    chk("R8 global bit 0", {63'h0, rsp_lo_word[0]}, 64'h1);
    chk("R8 mask", 64'(rsp_mask), 64'h3);

    // R7 hold without request
    @(negedge clk);
    chk("R7 valid low", 64'(rsp_valid), 64'h0);
    chk("R7 idx held", 64'(rsp_idx), 64'h2);

    // R5 out-of-range writes
    wr(4'd8, 21'h0, 21'h500, 8'd1, 1'b0, 26'h1002, 26'h0);
    wr(4'd15, 21'h0, 21'h500, 8'd1, 1'b0, 26'h1002, 26'h0);
    probe(21'h500, 8'd1);
    chk("R5 ignored write miss", 64'(prb_miss), 64'h1);
    look(21'h100, 8'd5);
    chk("R5 entry 0 unchanged", 64'(rsp_lo_word), 64'h445E);
    probe(21'h0, 8'h0);
    chk("R5 entry 1 still zero", 64'(prb_idx), 64'h1);

    // R10 write and lookup in the same cycle
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = 21'h600; lk_asid = 8'd2;
    wr_en = 1'b1; wr_idx = 4'd6; wr_mask = '0; wr_vpn = 21'h600; wr_asid = 8'd2; wr_glob = 1'b0;
    wr_lo_word = 26'h2002; wr_hi_word = 26'h0;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    chk("R10 same cycle sees old", 64'(rsp_hit), 64'h0);
    look(21'h600, 8'd2);
    chk("R10 next cycle hit", 64'(rsp_hit), 64'h1);
    chk("R10 next cycle idx", 64'(rsp_idx), 64'h6);

    // R6 flush beats a simultaneous write
    @(negedge clk);
    flush = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd4; wr_vpn = 21'h700; wr_asid = 8'd3; wr_lo_word = 26'h3002;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
    probe(21'h100, 8'd5);
    chk("R6 flushed entry gone", 64'(prb_miss), 64'h1);
    probe(21'h700, 8'd3);
    chk("R6 flush beats write", 64'(prb_miss), 64'h1);
    probe(21'h0, 8'h0);
    chk("R6 zero entry match", 64'(prb_idx), 64'h0);
    look(21'h0, 8'h0);
    chk("R6 zero entry words", {32'(rsp_lo_word), 32'(rsp_hi_word)}, 64'h0);
    chk("R6 zero hit idx", {63'(rsp_idx), rsp_hit}, 64'h1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule